// File: doc/BRIEF.md
# Ping-pong stream DMA channel pair

This block moves a continuous word stream between a serial link and on-chip memory. It needs no processor action per word. The receive side stores incoming link words in a circular buffer of 2×N words. The transmit side fetches outgoing words from a second circular buffer of the same shape. Both sides work on the same half index. While receive fills half 0, transmit sends from half 0. When the last receive word of a half is written, both sides move to half 1, and after half 1 they wrap back to half 0. Nothing is reprogrammed between passes.

Software writes the two base addresses and the half length N once, then sets the enable bit. The block then raises a sticky interrupt each time a half completes. The interrupt carries the index of the half that is now free for the processor. A completion that arrives while the interrupt is still pending sets an overrun flag. A link request that finds no prefetched transmit word sets an underrun flag. All three flags are cleared by write-one-to-clear bits in the control register.

The memory port is a single synchronous port with one-cycle read latency. Receive writes win over transmit prefetch reads, and a read that loses is retried.

Top module: `pingpong_stream_dma`

## Requirements
- R1: After reset, irq_o, irq_half_o, overrun_o, underrun_o and owned_half_o are 0, and no memory access is issued while disabled.
- R2: The k-th received word of half h (k from 0) is written to rx base + h×N + k. After word N-1 of half 1 the block wraps to half 0, word 0, with no configuration write.
- R3: The cycle after the last word of a half is written, owned_half_o toggles. In that same cycle irq_o is 1 and irq_half_o holds the index of the completed half.
- R4: The k-th transmit request in half h updates tx_data_o, on the cycle after the request, to the memory word at tx base + h×N + k. The transmit index restarts at 0 when the half changes.
- R5: A transmit request that arrives when no prefetched word is ready leaves tx_data_o unchanged and sets underrun_o. The next request then returns the next word in order.
- R6: A half completion while irq_o is still 1 sets overrun_o.
- R7: Control register writes (register select 0) have these fields: bit 0 is enable, and bit 1, bit 2 and bit 3 clear irq_o, overrun_o and underrun_o when written as 1. Register select 1 is rx base, 2 is tx base and 3 is the half length N.
- R8: Writes to rx base, tx base or half length are ignored while the channel is enabled.
- R9: A memory write and a memory read are never issued in the same cycle. A transmit read that loses to a receive write is retried, so transmit data stays correct after back-to-back receive words.
- R10: Clearing enable finishes the word in progress, then returns both sides to half 0, word 0. owned_half_o reads 0. The next enable starts at word 0 of half 0 with any base written while disabled.
- R11: tx_data_o changes only on the cycle after a transmit request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| rx_valid_i | input | 1 | Link word valid |
| rx_data_i | input | DATA_W | Link word in |
| tx_req_i | input | 1 | Link requests the next outgoing word |
| tx_data_o | output | DATA_W | Outgoing word |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after mem_re_o |
| irq_o | output | 1 | Sticky half-complete interrupt |
| irq_half_o | output | 1 | Index of the last completed half |
| overrun_o | output | 1 | Completion seen while interrupt pending |
| underrun_o | output | 1 | Transmit request with no word ready |
| owned_half_o | output | 1 | Half currently owned by the DMA |

## Verification
The assertions assume that mem_rdata_i carries the addressed word exactly one cycle after mem_re_o. The bench's memory model keeps to this. They also assume that the half length is at least 1 and that each buffer fits the address space. The bench configures N=4 with disjoint regions to meet that. A transmit request that lands on the same edge as a half switch is outside the defined ordering. The stimulus always leaves idle cycles between the last receive word of a half and the next request. Back-to-back receive bursts and paired transmit requests are used only where they test priority and underrun.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  typedef enum logic [1:0] {
    REG_CTRL     = 2'd0,
    REG_RX_BASE  = 2'd1,
    REG_TX_BASE  = 2'd2,
    REG_HALF_LEN = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN      = 0;
  localparam int unsigned CTRL_CLR_IRQ = 1;
  localparam int unsigned CTRL_CLR_OVR = 2;
  localparam int unsigned CTRL_CLR_UDR = 3;
endpackage

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 6,
  parameter int unsigned CFG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] rx_base_o,
  output logic [ADDR_W-1:0] tx_base_o,
  output logic [LEN_W-1:0]  half_len_o,
  output logic              clr_irq_o,
  output logic              clr_ovr_o,
  output logic              clr_udr_o
);
  reg_sel_e sel;
  logic     ctrl_wr;

  assign sel     = reg_sel_e'(addr_i);
  assign ctrl_wr = we_i && (sel == REG_CTRL);

  assign clr_irq_o = ctrl_wr && wdata_i[CTRL_CLR_IRQ];
  assign clr_ovr_o = ctrl_wr && wdata_i[CTRL_CLR_OVR];
  assign clr_udr_o = ctrl_wr && wdata_i[CTRL_CLR_UDR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      rx_base_o  <= '0;
      tx_base_o  <= '0;
      half_len_o <= '0;
    end else if (we_i) begin
      unique case (sel)
        REG_CTRL:     en_o <= wdata_i[CTRL_EN];
        REG_RX_BASE:  if (!en_o) rx_base_o  <= wdata_i[ADDR_W-1:0];
        REG_TX_BASE:  if (!en_o) tx_base_o  <= wdata_i[ADDR_W-1:0];
        REG_HALF_LEN: if (!en_o) half_len_o <= wdata_i[LEN_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pp_rx_side.sv
module pp_rx_side #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  half_len_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              half_o,
  output logic              done_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] idx;
  logic             last;

  assign last    = (idx == half_len_i - ONE);
  assign wr_o    = wr_o_q;
  assign done_o  = wr_o_q && en_i && last;
  assign waddr_o = base_i + (half_o ? ADDR_W'(half_len_i) : '0) + ADDR_W'(idx);

  logic wr_o_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o_q  <= 1'b0;
      wdata_o <= '0;
    end else begin
      wr_o_q <= en_i && rx_valid_i;
      if (en_i && rx_valid_i) wdata_o <= rx_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx    <= '0;
      half_o <= 1'b0;
    end else if (!en_i) begin
      idx    <= '0;
      half_o <= 1'b0;
    end else if (wr_o_q) begin
      if (last) begin
        idx    <= '0;
        half_o <= ~half_o;
      end else begin
        idx <= idx + ONE;
      end
    end
  end
endmodule

// File: rtl/pp_tx_side.sv
module pp_tx_side #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              half_i,
  input  logic              switch_i,
  input  logic              grant_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  half_len_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              tx_req_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              udr_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0]  idx;
  logic              ready;
  logic              pend;
  logic [DATA_W-1:0] word_q;

  assign rd_o    = en_i && !ready && !pend && grant_i;
  assign raddr_o = base_i + (half_i ? ADDR_W'(half_len_i) : '0) + ADDR_W'(idx);
  assign udr_o   = en_i && tx_req_i && !ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx    <= '0;
      ready  <= 1'b0;
      pend   <= 1'b0;
      word_q <= '0;
    end else if (!en_i || switch_i) begin
      idx   <= '0;
      ready <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pend <= rd_o;
      if (pend) begin
        word_q <= rdata_i;
        ready  <= 1'b1;
        idx    <= (idx == half_len_i - ONE) ? '0 : idx + ONE;
      end else if (tx_req_i && ready) begin
        ready <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_data_o <= '0;
    else if (en_i && tx_req_i && ready) tx_data_o <= word_q;
  end
endmodule

// File: rtl/pp_irq_flags.sv
module pp_irq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic done_half_i,
  input  logic udr_i,
  input  logic clr_irq_i,
  input  logic clr_ovr_i,
  input  logic clr_udr_i,
  output logic irq_o,
  output logic irq_half_o,
  output logic overrun_o,
  output logic underrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      irq_half_o <= 1'b0;
      overrun_o  <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      if (done_i) begin
        irq_o      <= 1'b1;
        irq_half_o <= done_half_i;
      end else if (clr_irq_i) begin
        irq_o <= 1'b0;
      end
      if (done_i && irq_o) overrun_o <= 1'b1;
      else if (clr_ovr_i)  overrun_o <= 1'b0;
      if (udr_i)           underrun_o <= 1'b1;
      else if (clr_udr_i)  underrun_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pingpong_stream_dma.sv
module pingpong_stream_dma #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 6,
  parameter int unsigned CFG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_req_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              irq_o,
  output logic              irq_half_o,
  output logic              overrun_o,
  output logic              underrun_o,
  output logic              owned_half_o
);
  logic              en;
  logic [ADDR_W-1:0] rx_base, tx_base, rx_addr, tx_addr;
  logic [LEN_W-1:0]  half_len;
  logic              clr_irq, clr_ovr, clr_udr;
  logic              rx_wr, rx_done, half, tx_rd, tx_udr;

  pp_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CFG_W(CFG_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .en_o(en), .rx_base_o(rx_base), .tx_base_o(tx_base), .half_len_o(half_len),
    .clr_irq_o(clr_irq), .clr_ovr_o(clr_ovr), .clr_udr_o(clr_udr)
  );

  pp_rx_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx (
    .clk_i, .rst_ni, .en_i(en),
    .rx_valid_i, .rx_data_i, .base_i(rx_base), .half_len_i(half_len),
    .wr_o(rx_wr), .waddr_o(rx_addr), .wdata_o(mem_wdata_o),
    .half_o(half), .done_o(rx_done)
  );

  pp_tx_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_tx (
    .clk_i, .rst_ni, .en_i(en),
    .half_i(half), .switch_i(rx_done), .grant_i(!rx_wr),
    .base_i(tx_base), .half_len_i(half_len), .rdata_i(mem_rdata_i),
    .tx_req_i, .rd_o(tx_rd), .raddr_o(tx_addr), .tx_data_o, .udr_o(tx_udr)
  );

  pp_irq_flags u_irq (
    .clk_i, .rst_ni,
    .done_i(rx_done), .done_half_i(half), .udr_i(tx_udr),
    .clr_irq_i(clr_irq), .clr_ovr_i(clr_ovr), .clr_udr_i(clr_udr),
    .irq_o, .irq_half_o, .overrun_o, .underrun_o
  );

  // receive write owns the port; the prefetch is gated by grant_i and retried
  assign mem_we_o     = rx_wr;
  assign mem_re_o     = tx_rd;
  assign mem_addr_o   = rx_wr ? rx_addr : tx_addr;
  assign owned_half_o = half;
endmodule

// File: rtl/pp_dma_checker.sv
module pp_dma_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              tx_req_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              irq_o,
  input logic              irq_half_o,
  input logic              overrun_o,
  input logic              underrun_o,
  input logic              owned_half_o
);
  assert_port_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  assert_half_switch_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (owned_half_o != $past(owned_half_o)))
      |-> (irq_o && (irq_half_o == $past(owned_half_o))));

  assert_irq_needs_switch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (owned_half_o != $past(owned_half_o)));

  assert_tx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_req_i |=> $stable(tx_data_o));

  assert_underrun_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(tx_req_i));

  assert_overrun_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(irq_o));

  assert_idle_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !$past(en_i)) |-> !mem_re_o);
endmodule

bind pingpong_stream_dma pp_dma_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
  .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
  .tx_req_i(tx_req_i), .tx_data_o(tx_data_o),
  .irq_o(irq_o), .irq_half_o(irq_half_o),
  .overrun_o(overrun_o), .underrun_o(underrun_o),
  .owned_half_o(owned_half_o)
);

// File: tb/pingpong_stream_dma_test.sv
`timescale 1ns/1ps
module pingpong_stream_dma_test;
  localparam int DW = 16, AW = 8, LW = 6, CW = 16, N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [DW-1:0] rx_data = '0, tx_data, mem_wdata, mem_rdata;
  logic mem_we, mem_re, irq, irq_half, ovr, udr, owned;
  logic [AW-1:0] mem_addr;

  always #4 clk = ~clk;

  pingpong_stream_dma #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW), .CFG_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_req_i(tx_req), .tx_data_o(tx_data),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .irq_o(irq), .irq_half_o(irq_half), .overrun_o(ovr), .underrun_o(udr),
    .owned_half_o(owned)
  );

  // memory model: one-cycle read latency, untouched words read as A000|addr
  logic [DW-1:0] mem [256];
  logic          written [256];
  int            conflicts = 0;

  function automatic logic [DW-1:0] mem_word(int a);
    return written[a] ? mem[a] : (16'hA000 | DW'(a));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) written[a] <= 1'b0;
    end else begin
      if (mem_we && mem_re) conflicts <= conflicts + 1;
      if (mem_we) begin
        mem[mem_addr]     <= mem_wdata;
        written[mem_addr] <= 1'b1;
      end
    end
    if (mem_re) mem_rdata <= mem_word(int'(mem_addr));
  end

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model state
  int rxb = 'h10, txb = 'h40;
  int h = 0, rj = 0, tj = 0, ih_e = 0;
  bit irq_e = 0, ovr_e = 0, udr_e = 0;
  int seq = 1;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear(input logic [3:0] bits);
    cfg_write(2'd0, CW'({bits[3:1], 1'b1}));
    if (bits[1]) irq_e = 0;
    if (bits[2]) ovr_e = 0;
    if (bits[3]) udr_e = 0;
    chk(irq == irq_e && ovr == ovr_e && udr == udr_e, "R7",
        {29'd0, irq, ovr, udr}, {29'd0, irq_e, ovr_e, udr_e});
  endtask

  // advance model by one received word, return its address
  function automatic int model_rx();
    int a;
    a = rxb + h * N + rj;
    rj++;
    if (rj == N) begin
      rj = 0;
      ovr_e = ovr_e | irq_e;
      irq_e = 1;
      ih_e = h;
      h ^= 1;
      tj = 0;
    end
    return a;
  endfunction

  task automatic check_flags(input string req);
    chk(owned == 1'(h), req, {31'd0, owned}, h);
    chk(irq == irq_e, req, {31'd0, irq}, {31'd0, irq_e});
    if (irq_e) chk(irq_half == 1'(ih_e), req, {31'd0, irq_half}, ih_e);
    chk(ovr == ovr_e, "R6", {31'd0, ovr}, {31'd0, ovr_e});
  endtask

  task automatic send_rx(output bit completed);
    int a, h0;
    logic [DW-1:0] d;
    d = 16'h5000 | DW'(seq); seq++;
    h0 = h;
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
    a = model_rx();
    chk(written[a] && mem[a] == d, "R2", {16'd0, mem[a]}, {16'd0, d});
    completed = (h != h0);
    check_flags("R3");
  endtask

  task automatic burst_rx(input int cnt);
    logic [DW-1:0] d [16];
    int a;
    for (int i = 0; i < cnt; i++) begin
      d[i] = 16'h5000 | DW'(seq); seq++;
      @(negedge clk); rx_valid = 1'b1; rx_data = d[i];
    end
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < cnt; i++) begin
      a = model_rx();
      chk(written[a] && mem[a] == d[i], "R2", {16'd0, mem[a]}, {16'd0, d[i]});
    end
    check_flags("R3");
  endtask

  task automatic do_tx(input string req);
    logic [DW-1:0] e;
    e = mem_word(txb + h * N + tj);
    tj = (tj + 1) % N;
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    chk(tx_data == e, req, {16'd0, tx_data}, {16'd0, e});
  endtask

  initial begin : main
    bit c;
    logic [DW-1:0] e0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(!irq && !irq_half && !ovr && !udr && !owned, "R1",
        {27'd0, irq, irq_half, ovr, udr, owned}, 0);
    chk(!mem_we && !mem_re, "R1", {30'd0, mem_we, mem_re}, 0);

    cfg_write(2'd1, CW'(rxb));
    cfg_write(2'd2, CW'(txb));
    cfg_write(2'd3, CW'(N));
    idle(3);
    chk(!mem_re && !mem_we, "R1", {30'd0, mem_we, mem_re}, 0);
    cfg_write(2'd0, 16'h1);
    idle(3);
    cfg_write(2'd1, 16'h80);   // ignored while enabled
    cfg_write(2'd3, 16'h2);    // ignored while enabled

    // two full buffer passes, one request then one word at a time
    for (int p = 0; p < 2 * 2 * N; p++) begin
      do_tx("R4");
      send_rx(c);
      idle(3);
      if (c) clear(4'b0010);
    end
    chk(!written['h80], "R8", {31'd0, written['h80]}, 0);

    // two completions without clearing
    for (int p = 0; p < 2 * N; p++) begin
      send_rx(c);
      idle(1);
    end
    chk(ovr == 1'b1, "R6", {31'd0, ovr}, 1);
    clear(4'b0110);

    // back-to-back receive words across a half switch, prefetch starved
    send_rx(c); send_rx(c);
    burst_rx(N + 2);
    clear(4'b0110);
    idle(3);
    do_tx("R9");
    idle(3);
    do_tx("R9");
    idle(3);
    chk(conflicts == 0, "R9", conflicts, 0);

    // two requests on consecutive cycles
    e0 = mem_word(txb + h * N + tj);
    tj = (tj + 1) % N;
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk);
    chk(tx_data == e0, "R4", {16'd0, tx_data}, {16'd0, e0});
    @(negedge clk); tx_req = 1'b0;
    chk(tx_data == e0, "R5", {16'd0, tx_data}, {16'd0, e0});
    chk(udr == 1'b1, "R5", {31'd0, udr}, 1);
    udr_e = 1;
    idle(3);
    do_tx("R5");
    clear(4'b1000);

    // disable mid-half, move rx base, re-enable
    send_rx(c);
    idle(2);
    cfg_write(2'd0, 16'h0);
    idle(2);
    chk(owned == 1'b0, "R10", {31'd0, owned}, 0);
    rxb = 'h20;
    cfg_write(2'd1, CW'(rxb));
    cfg_write(2'd0, 16'h1);
    h = 0; rj = 0; tj = 0;
    idle(3);
    do_tx("R10");
    send_rx(c);
    chk(written['h20], "R10", {31'd0, written['h20]}, 1);
    idle(2);
    chk(conflicts == 0, "R9", conflicts, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 8);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule